// File: doc/BRIEF.md
# Fully Associative Write-Through Cache

This block sits between a processor port and a slower main memory. It keeps a small set of lines, each holding one word together with the full address that the word belongs to. Every lookup compares the request address against all stored addresses in parallel. A read that finds its address is answered from the cache in the same cycle. A read that misses goes to main memory, and the returned word is both handed to the processor and placed into a line picked by a rotating replacement pointer.

Writes always go through to main memory. When a write finds its address already cached, only the word of that line is rewritten and its address tag is left alone. The line store therefore has two separate write enables per line, one for the tag and one for the data. When a write misses, the line at the replacement pointer takes both the new address and the new word. Both handshakes use request/acknowledge. The processor holds its request until it sees the acknowledge, and main memory may take any number of cycles to answer.

Top module: `assoc_wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses and raises `mem_req`.
- R2: At most one line ever matches a request address, because a tag is stored only when no valid line already holds it.
- R3: A read whose address is cached raises `cpu_ack` in the same cycle as `cpu_req`, returns the stored word on `cpu_rdata`, and raises no `mem_req`.
- R4: A read miss raises `mem_req` with `mem_we` low and `mem_addr` equal to `cpu_addr`. The cycle in which `mem_ack` rises also raises `cpu_ack` with `cpu_rdata` equal to `mem_rdata`.
- R5: Each line fill writes the line named by a mod-N pointer, which starts at line 0 after reset and advances by one for each fill only. After N+1 fills of distinct addresses, the first address is no longer cached.
- R6: Every write raises `mem_req` with `mem_we` high and the request's address and data, and it is acknowledged only together with `mem_ack`.
- R7: A write to a cached address changes only that line's word. A later read of that address hits with the new word, and the replacement pointer does not move.
- R8: A write miss loads the pointed line with the new address and word, and advances the pointer. A later read of that address hits with the written word.
- R9: `cpu_ack` is high only when `mem_ack` is high or a cached read is being served.
- R10: Once raised, `mem_req` stays high with an unchanged address until `mem_ack`, for any memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | DW | Write data |
| cpu_ack | output | 1 | Request completed |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` on reads |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write enable |
| mem_addr | output | AW | Main-memory address |
| mem_wdata | output | DW | Main-memory write data |
| mem_ack | input | 1 | Main-memory completion |
| mem_rdata | input | DW | Main-memory read data |

## Verification
The assertions check several rules on every cycle. No more than one line may match. A cache-only acknowledge must be a read hit with no memory request. Writes must complete only through memory. The memory request and address must hold until answered. Tags and the replacement pointer may change only after a fill. Whether the right word comes back, whether the pointer evicts the oldest line, and whether a write hit keeps its tag while changing its word can only be shown by the bench's access sequences, which compare results against a model of tags, pointer and memory under several memory latencies.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } ctl_state_t;

    // strobes issued by the controller to the line store
    typedef struct packed {
        logic fill;     // write tag and data of the victim line
        logic upd;      // write data only of the matching line
        logic from_mem; // select main-memory word as returned/filled data
    } line_cmd_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cache_line_store.sv
module cache_line_store #(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int DW = 4,
    parameter int IW = cache_pkg::idx_width(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   look_addr,
    input  logic            fill_en,
    input  logic [IW-1:0]   fill_idx,
    input  logic [DW-1:0]   fill_data,
    input  logic            upd_en,
    input  logic [DW-1:0]   upd_data,
    output logic [N-1:0]    match,
    output logic            hit,
    output logic [DW-1:0]   hit_data,
    output logic [N*AW-1:0] keys_flat
);

    logic [AW-1:0] key_q  [N];
    logic [DW-1:0] data_q [N];
    logic [N-1:0]  valid_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic key_we, data_we;
        assign key_we  = fill_en && (fill_idx == IW'(i));
        assign data_we = key_we || (upd_en && match[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
                key_q[i]   <= '0;
                data_q[i]  <= '0;
            end else begin
                if (key_we) begin
                    valid_q[i] <= 1'b1;
                    key_q[i]   <= look_addr;
                end
                if (data_we) begin
                    data_q[i] <= key_we ? fill_data : upd_data;
                end
            end
        end

        assign match[i] = valid_q[i] && (key_q[i] == look_addr);
        assign keys_flat[i*AW +: AW] = key_q[i];
    end

    assign hit = |match;

    always_comb begin
        hit_data = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_data = hit_data | data_q[i];
        end
    end

endmodule

// File: rtl/cache_victim_ptr.sv
module cache_victim_ptr #(
    parameter int N  = 4,
    parameter int IW = cache_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cpu_req,
    input  logic      cpu_we,
    input  logic      hit,
    input  logic      mem_ack,
    output logic      cpu_ack,
    output logic      mem_req,
    output line_cmd_t cmd
);

    ctl_state_t state_q, state_d;
    logic cache_ack;

    always_comb begin
        state_d   = state_q;
        cache_ack = 1'b0;
        mem_req   = 1'b0;
        cmd       = '0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_we && hit) cache_ack = 1'b1;
                    else                state_d   = ST_MEM;
                end
            end
            ST_MEM: begin
                mem_req      = 1'b1;
                cmd.from_mem = !cpu_we;
                if (mem_ack) begin
                    state_d = ST_IDLE;
                    if (cpu_we && hit) cmd.upd  = 1'b1;
                    else               cmd.fill = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // processor acknowledge: cached read OR memory completion
    assign cpu_ack = cache_ack || (mem_req && mem_ack);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/assoc_wt_cache.sv
module assoc_wt_cache
    import cache_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ack,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    localparam int IW = idx_width(N);

    logic [N-1:0]    match;
    logic            hit;
    logic [DW-1:0]   hit_data;
    logic [N*AW-1:0] keys_flat;
    logic [IW-1:0]   vidx;
    line_cmd_t       cmd;
    logic [DW-1:0]   fill_word;

    cache_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cpu_req (cpu_req),
        .cpu_we  (cpu_we),
        .hit     (hit),
        .mem_ack (mem_ack),
        .cpu_ack (cpu_ack),
        .mem_req (mem_req),
        .cmd     (cmd)
    );

    cache_victim_ptr #(.N(N), .IW(IW)) u_vptr (
        .clk (clk),
        .rst (rst),
        .adv (cmd.fill),
        .idx (vidx)
    );

    assign fill_word = cmd.from_mem ? mem_rdata : cpu_wdata;

    cache_line_store #(.N(N), .AW(AW), .DW(DW), .IW(IW)) u_lines (
        .clk       (clk),
        .rst       (rst),
        .look_addr (cpu_addr),
        .fill_en   (cmd.fill),
        .fill_idx  (vidx),
        .fill_data (fill_word),
        .upd_en    (cmd.upd),
        .upd_data  (cpu_wdata),
        .match     (match),
        .hit       (hit),
        .hit_data  (hit_data),
        .keys_flat (keys_flat)
    );

    assign cpu_rdata = cmd.from_mem ? mem_rdata : hit_data;
    assign mem_we    = cpu_we;
    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;

endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int IW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cpu_req,
    input logic            cpu_we,
    input logic            cpu_ack,
    input logic            mem_req,
    input logic            mem_ack,
    input logic [AW-1:0]   mem_addr,
    input logic [N-1:0]    match,
    input logic            fill_en,
    input logic [IW-1:0]   vidx,
    input logic [N*AW-1:0] keys_flat
);

    // R2
    p_one_match_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R3
    p_cache_ack_read_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && !mem_ack) |-> (!cpu_we && !mem_req && (|match)));

    // R6
    p_write_via_mem_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_ack) |-> (mem_req && mem_ack));

    // R9
    p_ack_source_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> (mem_ack || (|match)));

    // R10
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    p_ptr_on_fill_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(vidx) |-> $past(fill_en));

    // R7
    p_tag_on_fill_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(keys_flat) |-> $past(fill_en));

endmodule

bind assoc_wt_cache cache_chk #(.N(N), .AW(AW), .IW(IW)) u_cache_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_ack   (cpu_ack),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .match     (match),
    .fill_en   (cmd.fill),
    .vidx      (vidx),
    .keys_flat (keys_flat)
);

// File: tb/test_assoc_wt_cache.sv
module test_assoc_wt_cache;

    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 4;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int mem_wait = 0;
    int wcnt = 0;

    logic [DW-1:0] bmem [MSZ];

    // bench model of the cache contents
    logic [AW-1:0] m_key [N];
    logic [DW-1:0] m_dat [N];
    logic          m_val [N];
    int            m_ptr = 0;

    always #5 clk = ~clk;

    assoc_wt_cache #(.N(N), .AW(AW), .DW(DW)) i_assoc_wt_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // main memory with a configurable wait count
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= mem_wait) begin
                mem_ack   <= 1'b1;
                mem_rdata <= bmem[mem_addr];
                if (mem_we) bmem[mem_addr] <= mem_wdata;
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_key[i] == a) return i;
        return -1;
    endfunction

    // one processor access; checks handshake, data and memory traffic
    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input string req);
        int  line = model_find(a);
        bit  saw_mem = 0;
        int  cyc = 0;
        logic [DW-1:0] exp_rd = (line >= 0) ? m_dat[line] : bmem[a];
        logic [DW-1:0] got_rd = '0;
        logic got_mwe = 1'b0;
        logic [AW-1:0] got_ma = '0;
        logic [DW-1:0] got_md = '0;
        cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
        forever begin
            #1;
            if (mem_req) saw_mem = 1;
            if (cpu_ack) begin
                got_rd = cpu_rdata; got_mwe = mem_we; got_ma = mem_addr; got_md = mem_wdata;
                break;
            end
            cyc++;
            if (cyc > 200) break;
            @(negedge clk);
        end
        cpu_req = 1'b0;
        chk(cyc <= 200, {req, " ack seen"}, cyc, 0);
        if (!we && line >= 0) begin
            chk(cyc == 0, {req, " R3 hit latency"}, cyc, 0);
            chk(!saw_mem, {req, " R3 no mem_req on hit"}, saw_mem, 0);
            chk(got_rd == exp_rd, {req, " R3 hit data"}, got_rd, exp_rd);
        end else if (!we) begin
            chk(saw_mem, {req, " R4 mem_req on miss"}, saw_mem, 1);
            chk(got_mwe == 1'b0 && got_ma == a, {req, " R4 mem read addr"}, got_ma, a);
            chk(got_rd == exp_rd, {req, " R4 miss data"}, got_rd, exp_rd);
            m_key[m_ptr] = a; m_dat[m_ptr] = exp_rd; m_val[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % N;
        end else begin
            chk(saw_mem && got_mwe, {req, " R6 write forwarded"}, got_mwe, 1);
            chk(got_ma == a && got_md == d, {req, " R6 write addr/data"}, got_md, d);
            if (line >= 0) begin
                m_dat[line] = d;
            end else begin
                m_key[m_ptr] = a; m_dat[m_ptr] = d; m_val[m_ptr] = 1;
                m_ptr = (m_ptr + 1) % N;
            end
        end
        @(negedge clk);
        if (we) chk(bmem[a] == d, {req, " R6 memory updated"}, bmem[a], d);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) m_val[i] = 0;
        m_ptr = 0;
        #1;
        chk(!cpu_ack, "R1 reset cpu_ack", cpu_ack, 0);
        chk(!mem_req, "R1 reset mem_req", mem_req, 0);
        @(negedge clk);
    endtask

    task automatic t_miss_then_hit();
        mem_wait = 2;
        access(1'b0, 4'd3, 'x, "R1 first read misses");
        access(1'b0, 4'd3, 'x, "R3 repeat read");
        access(1'b0, 4'd9, 'x, "R4 second miss");
        access(1'b0, 4'd9, 'x, "R3 second hit");
    endtask

    task automatic t_write_hit();
        mem_wait = 3;
        access(1'b1, 4'd3, 4'hA, "R7 write hit");
        access(1'b0, 4'd3, 'x, "R7 read after write hit");
        // pointer must still name line 2: two more fills then line 0 (addr 3) goes
        access(1'b0, 4'd5, 'x, "R7 fill line2");
        access(1'b0, 4'd6, 'x, "R7 fill line3");
        access(1'b0, 4'd3, 'x, "R7 addr3 still cached");
    endtask

    task automatic t_round_robin();
        mem_wait = 0;
        access(1'b0, 4'd12, 'x, "R5 fill evicts line0");
        chk(model_find(4'd3) < 0, "R5 model evicted 3", model_find(4'd3), -1);
        access(1'b0, 4'd3, 'x, "R5 evicted address misses");
        access(1'b0, 4'd9, 'x, "R5 refill");
    endtask

    task automatic t_write_miss();
        mem_wait = 1;
        access(1'b1, 4'd14, 4'h7, "R8 write miss");
        access(1'b0, 4'd14, 'x, "R8 read after write miss");
        access(1'b1, 4'd14, 4'h1, "R2 rewrite same address");
        access(1'b0, 4'd14, 'x, "R2 read unique line");
    endtask

    task automatic t_latency();
        for (int w = 0; w < 6; w++) begin
            mem_wait = w;
            access(1'b0, AW'(w), 'x, "R10 variable latency read");
            access(1'b1, AW'(w + 8), DW'(w + 3), "R10 variable latency write");
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < MSZ; i++) bmem[i] = DW'(i * 5 + 1);
        @(negedge clk);
        t_reset();
        t_miss_then_hit();
        t_write_hit();
        t_round_robin();
        t_write_miss();
        t_latency();
        t_reset();
        access(1'b0, 4'd9, 'x, "R1 miss after second reset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule